// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Debug Tunnel

This block is a serial test port clocked by TCK. A 16-state controller is steered by TMS. It holds a 4-bit instruction and routes the serial path from TDI to TDO through one data register chosen by that instruction. The choices are a 32-bit identification register, a boundary chain of capture/shift/update cells around every pin, a one-bit bypass cell, or a byte-wide register that carries debug traffic between the port and the core.

The instruction also decides what drives the pins:
- the core's normal output and enable;
- the boundary output latches (clamp);
- nothing, because every enable is forced low (high impedance).

The debug byte path uses valid/ready handshakes on both sides:
- **Core-to-port byte.** It is offered with `dbg_in_valid`. It is taken only in the Capture-DR cycle of the debug instruction, and the handshake completes on that TCK edge.
- **Port-to-core byte.** It is presented with `dbg_out_valid` and held stable until the core raises `dbg_out_ready`. An Update-DR that arrives while a byte is still pending is discarded. That is the back-pressure rule.

All logic runs on TCK. Only the TDO retiming flops use the falling edge. `trst_n` is an asynchronous active-low reset.

Top module: `scan_tap`

## Requirements
- R1: Asserting `trst_n`, or five TCK rising edges with TMS high, puts the controller in Test-Logic-Reset. Reset loads instruction 0x3 (identify), so the pins follow the core and `dbg_out_valid` is low.
- R2: In Capture-IR the instruction shift register loads 4'b0001. Shift-IR moves it out on TDO least-significant bit first, while TDI enters at the top bit.
- R3: Instruction 0x3 selects a 32-bit register. Capture-DR loads `ID_VALUE`, and Shift-DR moves it out least-significant bit first.
- R4: Instruction 0xF selects a one-bit bypass cell. Capture-DR loads 0 into it, and during Shift-DR TDO repeats TDI delayed by one TCK.
- R5: Every opcode other than 0x2, 0x3, 0x4, 0x5, 0x7 and 0xF behaves as 0xF, with the pins left under core control.
- R6: Instruction 0x2 selects a boundary chain of 3*NPIN cells. For pin k, cell 3k captures `pad_in[k]`, cell 3k+1 captures `core_out[k]` and cell 3k+2 captures `core_oe[k]`. TDI enters the highest cell and TDO reads cell 0.
- R7: The output latches (`pad_out` value and enable, per pin) load from cells 3k+1 and 3k+2 only in Update-DR of instruction 0x2. Under 0x2 the pins keep following the core.
- R8: Instruction 0x4 drives `pad_out`/`pad_oe` from the output latches, with the bypass cell as the data register.
- R9: Instruction 0x5 forces every `pad_oe` bit low while `pad_out` follows the core, with the bypass cell as the data register.
- R10: The pin control mode changes only at Update-IR or in Test-Logic-Reset. Data-register scans never alter it.
- R11: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. TDO changes only on the falling edge of TCK, and TDO is 0 while `tdo_oe` is low.
- R12: Instruction 0x7 selects a DBG_W-bit register. In Capture-DR it loads `dbg_in_data` and raises `dbg_in_ready` in that cycle if `dbg_in_valid` is high; otherwise it loads 0 and no handshake occurs.
- R13: Update-DR of instruction 0x7 presents the shifted byte on `dbg_out_data` with `dbg_out_valid` high. The data is held stable until `dbg_out_ready`. An update arriving while a byte is pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | High while TDO carries shift data |
| pad_in | input | NPIN | Values seen on the pins |
| core_out | input | NPIN | Core's normal pin output values |
| core_oe | input | NPIN | Core's normal pin output enables |
| pad_out | output | NPIN | Value driven toward the pins |
| pad_oe | output | NPIN | Enable driven toward the pins |
| dbg_in_data | input | DBG_W | Byte offered by the core |
| dbg_in_valid | input | 1 | Core byte is valid |
| dbg_in_ready | output | 1 | Port takes the core byte this cycle |
| dbg_out_data | output | DBG_W | Byte delivered to the core |
| dbg_out_valid | output | 1 | Delivered byte is valid |
| dbg_out_ready | input | 1 | Core accepts the delivered byte |

## Verification
The assertions check the following on every TCK edge:
- the five-ones reset rule;
- the Capture-IR constant;
- the pin mode holding still outside Update-IR and reset;
- the output latches holding between updates;
- the high-impedance override;
- `tdo_oe` tracking the shift states;
- the debug handshake loading the offered byte and holding a pending byte.

Only the bench's scans can show the following:
- that each opcode routes the correct register length and content to TDO;
- the boundary cell ordering;
- clamp values reaching the pins after a preload;
- that a dropped debug update leaves the pending byte untouched.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OPC_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OPC_IDENT  = 4'h3;
  localparam logic [IR_W-1:0] OPC_CLAMP  = 4'h4;
  localparam logic [IR_W-1:0] OPC_HIGHZ  = 4'h5;
  localparam logic [IR_W-1:0] OPC_DBG    = 4'h7;
  localparam logic [IR_W-1:0] OPC_BYPASS = 4'hF;

  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 4'b0001;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_CHAIN, DR_DBG} dr_sel_e;
  typedef enum logic [1:0] {PIN_CORE, PIN_LATCH, PIN_OFF} pin_mode_e;

endpackage

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end

  // run of consecutive TMS-high samples, saturating at five
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            tms_run <= 3'd0;
    else if (!tms)          tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
    tms_run == 3'd5 |-> state == TS_RESET);

endmodule

// File: rtl/scan_tap_decode.sv
`timescale 1ns/1ps
module scan_tap_decode
  import scan_tap_pkg::*;
#(
  parameter int HAS_ID = 1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_tdo,
  output dr_sel_e    dr_sel,
  output pin_mode_e  pin_mode
);

  localparam logic [IR_W-1:0] RESET_OP = (HAS_ID != 0) ? OPC_IDENT : OPC_BYPASS;

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
    end else if (state == TS_CAP_IR) begin
      ir_sr <= IR_CAPTURE_VAL;
    end else if (state == TS_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= RESET_OP;
    else if (state == TS_RESET)  ir_q <= RESET_OP;
    else if (state == TS_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_tdo = ir_sr[0];

  always_comb begin
    dr_sel   = DR_BYPASS;
    pin_mode = PIN_CORE;
    case (ir_q)
      OPC_SAMPLE: dr_sel = DR_CHAIN;
      OPC_IDENT:  dr_sel = (HAS_ID != 0) ? DR_IDENT : DR_BYPASS;
      OPC_CLAMP:  pin_mode = PIN_LATCH;
      OPC_HIGHZ:  pin_mode = PIN_OFF;
      OPC_DBG:    dr_sel = DR_DBG;
      default:    dr_sel = DR_BYPASS;
    endcase
  end

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
    state == TS_CAP_IR |=> ir_sr == IR_CAPTURE_VAL);

  assert_mode_hold_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(pin_mode));

endmodule

// File: rtl/scan_tap_bchain.sv
`timescale 1ns/1ps
module scan_tap_bchain #(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            tdi,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic            tdo,
  output logic [NPIN-1:0] lat_out,
  output logic [NPIN-1:0] lat_oe
);

  localparam int CLEN = 3 * NPIN;

  logic [CLEN-1:0] cells;
  logic [CLEN-1:0] cap_val;
  logic [CLEN-1:0] feed;
  logic [NPIN-1:0] cell_out;
  logic [NPIN-1:0] cell_oe;

  assign feed = {tdi, cells[CLEN-1:1]};

  // per pin: input observe cell, output value cell, output enable cell
  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign cap_val[3*p]   = pad_in[p];
      assign cap_val[3*p+1] = core_out[p];
      assign cap_val[3*p+2] = core_oe[p];
      assign cell_out[p]    = cells[3*p+1];
      assign cell_oe[p]     = cells[3*p+2];
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       cells <= '0;
    else if (cap_en)   cells <= cap_val;
    else if (shift_en) cells <= feed;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      lat_out <= '0;
      lat_oe  <= '0;
    end else if (upd_en) begin
      lat_out <= cell_out;
      lat_oe  <= cell_oe;
    end
  end

  assign tdo = cells[0];

  assert_latch_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> ($stable(lat_out) && $stable(lat_oe)));

endmodule

// File: rtl/scan_tap_dbgreg.sv
`timescale 1ns/1ps
module scan_tap_dbgreg #(
  parameter int DBG_W = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  input  logic             tdi,
  output logic             tdo,
  input  logic [DBG_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [DBG_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);

  logic [DBG_W-1:0] sr;

  assign in_ready = cap_en && in_valid;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sr <= '0;
    else if (cap_en)   sr <= in_valid ? in_data : '0;
    else if (shift_en) sr <= {tdi, sr[DBG_W-1:1]};
  end

  // a pending byte blocks later updates; they are discarded
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end else if (upd_en && !out_valid) begin
      out_valid <= 1'b1;
      out_data  <= sr;
    end
  end

  assign tdo = sr[0];

  assert_in_take_R12: assert property (@(posedge tck) disable iff (!trst_n)
    (in_valid && in_ready) |=> sr == $past(in_data));

  assert_out_hold_R13: assert property (@(posedge tck) disable iff (!trst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          NPIN     = 4,
  parameter int          DBG_W    = 8,
  parameter int          HAS_ID   = 1,
  parameter logic [31:0] ID_VALUE = 32'h4B1C_503F
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NPIN-1:0]  pad_in,
  input  logic [NPIN-1:0]  core_out,
  input  logic [NPIN-1:0]  core_oe,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe,
  input  logic [DBG_W-1:0] dbg_in_data,
  input  logic             dbg_in_valid,
  output logic             dbg_in_ready,
  output logic [DBG_W-1:0] dbg_out_data,
  output logic             dbg_out_valid,
  input  logic             dbg_out_ready
);

  localparam int ID_W = 32;

  tap_state_e state;
  dr_sel_e    dr_sel;
  pin_mode_e  pin_mode;
  logic       ir_tdo;

  scan_tap_ctrl u_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  scan_tap_decode #(.HAS_ID(HAS_ID)) u_dec (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_tdo(ir_tdo), .dr_sel(dr_sel), .pin_mode(pin_mode)
  );

  logic cap_dr, sh_dr, up_dr, sh_ir, shifting;
  assign cap_dr   = (state == TS_CAP_DR);
  assign sh_dr    = (state == TS_SH_DR);
  assign up_dr    = (state == TS_UPD_DR);
  assign sh_ir    = (state == TS_SH_IR);
  assign shifting = sh_dr || sh_ir;

  // boundary chain
  logic            chain_tdo;
  logic [NPIN-1:0] lat_out, lat_oe;
  logic            is_chain;
  assign is_chain = (dr_sel == DR_CHAIN);

  scan_tap_bchain #(.NPIN(NPIN)) u_chain (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr && is_chain), .shift_en(sh_dr && is_chain), .upd_en(up_dr && is_chain),
    .tdi(tdi), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .tdo(chain_tdo), .lat_out(lat_out), .lat_oe(lat_oe)
  );

  // debug byte register
  logic dbg_tdo, is_dbg;
  assign is_dbg = (dr_sel == DR_DBG);

  scan_tap_dbgreg #(.DBG_W(DBG_W)) u_dbg (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr && is_dbg), .shift_en(sh_dr && is_dbg), .upd_en(up_dr && is_dbg),
    .tdi(tdi), .tdo(dbg_tdo),
    .in_data(dbg_in_data), .in_valid(dbg_in_valid), .in_ready(dbg_in_ready),
    .out_data(dbg_out_data), .out_valid(dbg_out_valid), .out_ready(dbg_out_ready)
  );

  // identification and bypass registers
  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                            id_sr <= '0;
    else if (cap_dr && dr_sel == DR_IDENT)  id_sr <= ID_VALUE;
    else if (sh_dr && dr_sel == DR_IDENT)   id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                             byp_q <= 1'b0;
    else if (cap_dr && dr_sel == DR_BYPASS)  byp_q <= 1'b0;
    else if (sh_dr && dr_sel == DR_BYPASS)   byp_q <= tdi;
  end

  // serial output select, retimed on the falling edge
  logic tdo_next;
  always_comb begin
    if (sh_ir) tdo_next = ir_tdo;
    else begin
      unique case (dr_sel)
        DR_IDENT: tdo_next = id_sr[0];
        DR_CHAIN: tdo_next = chain_tdo;
        DR_DBG:   tdo_next = dbg_tdo;
        default:  tdo_next = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      tdo    <= shifting ? tdo_next : 1'b0;
    end
  end

  // pin steering
  always_comb begin
    unique case (pin_mode)
      PIN_LATCH: begin pad_out = lat_out;  pad_oe = lat_oe; end
      PIN_OFF:   begin pad_out = core_out; pad_oe = '0;     end
      default:   begin pad_out = core_out; pad_oe = core_oe; end
    endcase
  end

  assert_highz_pins_R9: assert property (@(posedge tck) disable iff (!trst_n)
    pin_mode == PIN_OFF |-> $countones(pad_oe) == 0);

  assert_tdo_drive_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == TS_SH_DR || state == TS_SH_IR));

  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);

endmodule

// File: tb/scan_tap_test.sv
`timescale 1ns/1ps
module scan_tap_test;

  localparam int          NPIN = 4;
  localparam int          DBG_W = 8;
  localparam logic [31:0] IDV = 32'h4B1C_503F;
  localparam int          CLEN = 3 * NPIN;

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic             trst_n, tms, tdi;
  logic             tdo, tdo_oe;
  logic [NPIN-1:0]  pad_in, core_out, core_oe, pad_out, pad_oe;
  logic [DBG_W-1:0] dbg_in_data, dbg_out_data;
  logic             dbg_in_valid, dbg_in_ready, dbg_out_valid, dbg_out_ready;

  scan_tap #(.NPIN(NPIN), .DBG_W(DBG_W), .HAS_ID(1), .ID_VALUE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .dbg_in_data(dbg_in_data), .dbg_in_valid(dbg_in_valid), .dbg_in_ready(dbg_in_ready),
    .dbg_out_data(dbg_out_data), .dbg_out_valid(dbg_out_valid), .dbg_out_ready(dbg_out_ready)
  );

  int checks = 0;
  int errors = 0;
  int takes  = 0;
  bit done   = 1'b0;

  always @(posedge tck) if (dbg_in_valid && dbg_in_ready) takes++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one TCK: drive after the falling edge, sample TDO there, then take the rising edge
  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck);
  endtask

  task automatic step(input logic m);
    logic unused;
    tick(m, 1'b0, unused);
  endtask

  task automatic settle();
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic b;
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i], b);
      cap[i] = b;
    end
    step(1); step(0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic b;
    dout = '0;
    step(1); step(0); step(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], b);
      dout[i] = b;
    end
    step(1); step(0);
  endtask

  function automatic logic [CLEN-1:0] chain_img(input logic [NPIN-1:0] i,
                                                input logic [NPIN-1:0] o,
                                                input logic [NPIN-1:0] e);
    logic [CLEN-1:0] v;
    for (int k = 0; k < NPIN; k++) begin
      v[3*k]   = i[k];
      v[3*k+1] = o[k];
      v[3*k+2] = e[k];
    end
    return v;
  endfunction

  // {opcode, expected pin mode: 0 core, 1 latches, 2 high impedance}
  localparam logic [5:0] VEC [6] = '{
    {4'hF, 2'd0}, {4'h4, 2'd1}, {4'h5, 2'd2},
    {4'h0, 2'd0}, {4'h9, 2'd0}, {4'hE, 2'd0}
  };

  localparam logic [NPIN-1:0] PRE_OUT = 4'b0101;
  localparam logic [NPIN-1:0] PRE_OE  = 4'b1100;

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] dout;
    logic        v0, v1;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pad_in = 4'b0110; core_out = 4'b1001; core_oe = 4'b0011;
    dbg_in_data = '0; dbg_in_valid = 1'b0; dbg_out_ready = 1'b0;

    repeat (3) @(posedge tck);
    settle();
    check("R1 reset tdo_oe", 64'(tdo_oe), 64'(0));
    check("R1 reset pad_out", 64'(pad_out), 64'(core_out));
    check("R1 reset pad_oe", 64'(pad_oe), 64'(core_oe));
    check("R1 reset dbg_out_valid", 64'(dbg_out_valid), 64'(0));
    trst_n = 1'b1;

    repeat (5) step(1);
    step(0);

    // R3: the identify instruction is active after reset
    shift_dr(32, 64'(0), dout);
    check("R3 ident value", dout, 64'(IDV));

    // R2, R6, R7: sample then preload
    load_ir(4'h2, cap);
    check("R2 capture-IR", 64'(cap), 64'(4'b0001));
    shift_dr(CLEN, 64'(chain_img(4'b1111, PRE_OUT, PRE_OE)), dout);
    check("R6 chain capture", dout, 64'(chain_img(pad_in, core_out, core_oe)));
    settle();
    check("R7 pins stay core out", 64'(pad_out), 64'(core_out));
    check("R7 pins stay core oe", 64'(pad_oe), 64'(core_oe));
    pad_in = 4'b1011; core_out = 4'b0110;
    shift_dr(CLEN, 64'(chain_img(4'b0000, PRE_OUT, PRE_OE)), dout);
    check("R6 chain capture second", dout, 64'(chain_img(pad_in, core_out, core_oe)));
    core_out = 4'b1001;

    // table walk: R4 R5 R8 R9 R10
    for (int t = 0; t < 6; t++) begin
      load_ir(VEC[t][5:2], cap);
      check("R2 capture-IR in walk", 64'(cap), 64'(4'b0001));
      shift_dr(8, 64'(8'hA5), dout);
      check("R4 R5 bypass one-bit delay", dout, 64'({7'h25, 1'b0}));
      settle();
      case (VEC[t][1:0])
        2'd1: begin
          check("R8 clamp pad_out", 64'(pad_out), 64'(PRE_OUT));
          check("R8 clamp pad_oe", 64'(pad_oe), 64'(PRE_OE));
        end
        2'd2: begin
          check("R9 highz pad_oe", 64'(pad_oe), 64'(0));
          check("R9 highz pad_out", 64'(pad_out), 64'(core_out));
        end
        default: begin
          check("R5 core pad_out", 64'(pad_out), 64'(core_out));
          check("R5 core pad_oe", 64'(pad_oe), 64'(core_oe));
        end
      endcase
    end

    // R10: clamp persists through a data scan, released by TMS reset (R1)
    load_ir(4'h4, cap);
    shift_dr(4, 64'(4'hF), dout);
    settle();
    check("R10 clamp held after DR scan", 64'(pad_out), 64'(PRE_OUT));
    repeat (5) step(1);
    step(0);
    settle();
    check("R1 R10 reset returns pins to core", 64'(pad_oe), 64'(core_oe));
    shift_dr(32, 64'(0), dout);
    check("R1 ident after TMS reset", dout, 64'(IDV));

    // R11: tdo timing with bypass
    load_ir(4'hF, cap);
    settle();
    check("R11 tdo_oe idle", 64'(tdo_oe), 64'(0));
    step(1); step(0); step(0);
    tdi = 1'b1;
    settle();
    check("R11 tdo_oe in shift", 64'(tdo_oe), 64'(1));
    v0 = tdo;
    @(posedge tck); #1;
    v1 = tdo;
    check("R11 tdo stable across rising edge", 64'(v1), 64'(v0));
    settle();
    check("R11 tdo after falling edge", 64'(tdo), 64'(1));
    step(1); step(1); step(0);
    settle();
    check("R11 tdo quiet after scan", 64'({tdo_oe, tdo}), 64'(0));

    // R12, R13: debug byte path
    load_ir(4'h7, cap);
    dbg_in_data = 8'h3C; dbg_in_valid = 1'b1;
    shift_dr(8, 64'(8'h96), dout);
    dbg_in_valid = 1'b0;
    check("R12 captured core byte", dout, 64'(8'h3C));
    check("R12 one handshake", 64'(takes), 64'(1));
    settle();
    check("R13 out valid", 64'(dbg_out_valid), 64'(1));
    check("R13 out data", 64'(dbg_out_data), 64'(8'h96));
    shift_dr(8, 64'(8'h11), dout);
    check("R12 empty capture is zero", dout, 64'(0));
    check("R12 no handshake without valid", 64'(takes), 64'(1));
    settle();
    check("R13 pending byte kept", 64'(dbg_out_data), 64'(8'h96));
    dbg_out_ready = 1'b1;
    step(0);
    dbg_out_ready = 1'b0;
    settle();
    check("R13 valid cleared on accept", 64'(dbg_out_valid), 64'(0));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule